// File: doc/BRIEF.md
# Programmable Clock Output Divider with Retimed Enable

This block sits after a VCO and produces six identical clock output pairs, each a true signal and its complement. A 3-bit code selects the divide ratio. The ratios 2, 4, 8 and 16 come from a toggle stage, so the duty cycle is 50%. One code passes the VCO clock straight through.

An asynchronous output-enable input goes through a two-stage synchronizer on the rising edge and is then retimed on the falling edge of the VCO clock. When the enable is low, every true output sits low and every complement sits high. A synchronous active-high master reset clears the divider and forces the same state.

A new divide code takes effect only when the current output period has completed. A change of ratio therefore never produces a shortened pulse.

Top module: `odiv_top`

## Requirements
- R1: Codes 3'b000, 3'b001, 3'b010 and 3'b011 divide the VCO clock by 2, 4, 8 and 16.
- R2: Codes 3'b101, 3'b110 and 3'b111 divide the VCO clock by 2, 4 and 8.
- R3: Code 3'b100 passes the VCO clock through. While enabled, the true output is high during the high phase and low during the low phase of each VCO cycle.
- R4: In a divide-by-N mode the true output is low for the first N/2 VCO cycles of each period and high for the remaining N/2.
- R5: While the retimed enable is low, all true outputs are low and all complement outputs are high, whatever the divide code.
- R6: The enable input is sampled on two successive rising VCO edges and applied at the falling edge that follows the second one. A level present before rising edge k therefore reaches the outputs at the falling edge after rising edge k+1.
- R7: A master reset sampled high on a rising edge clears the divider and the synchronizer. While reset stays high, the outputs are low (complements high) from the next falling edge onward.
- R8: All six true outputs carry the same value, and each complement is the inverse of its true output.
- R9: A new code is taken at the rising edge that ends a complete output period, or at any rising edge while in pass-through. The new period starts with its low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | VCO clock, the only clock |
| rst | input | 1 | Master reset, active high, synchronous |
| oe_async | input | 1 | Output enable, asynchronous, active high |
| div_code | input | 3 | Divide code, decoded per R1 to R3 |
| fout | output | 6 | True clock outputs |
| fout_n | output | 6 | Complement clock outputs |

## Verification
The hardest situations to reach from the ports come from timing that varies with the state of the divider. One is a code change written in the middle of a long period, which must wait for that period's last cycle. The other is an enable pulse one VCO cycle wide, which must still emerge whole, retimed at a falling edge.

The stimulus writes codes at several offsets inside divide-by-16 and divide-by-8 periods and switches in and out of pass-through. It also toggles the enable for single cycles in both pass-through and divided modes. A behavioural model in the bench tracks the period phase and compares both the high and the low half of every VCO cycle.

// File: rtl/odiv_pkg.sv
package odiv_pkg;

    localparam int CODE_W = 3;
    localparam int HALF_W = 4;
    localparam logic [CODE_W-1:0] CODE_PASS = 3'b100;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_t;

    typedef struct packed {
        logic              pass;
        logic [HALF_W-1:0] half;
    } div_cfg_t;

    // Half-period length in VCO cycles for a divide code.
    function automatic div_cfg_t decode_code(input logic [CODE_W-1:0] c);
        div_cfg_t   r;
        logic [1:0] sh;
        sh     = c[1:0] - {1'b0, c[2]};
        r.pass = (c == CODE_PASS);
        if (r.pass) r.half = HALF_W'(1);
        else        r.half = HALF_W'(1) << sh;
        return r;
    endfunction

endpackage

// File: rtl/odiv_oe_sync.sv
module odiv_oe_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic oe_async,
    output logic en_ret
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[TOP-1:0], oe_async};
    end

    // Falling-edge retime keeps a gated clock free of glitches.
    always_ff @(negedge clk) begin
        if (rst) en_ret <= 1'b0;
        else     en_ret <= stg[TOP];
    end

    AST_EN_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (rst)
        en_ret == stg[TOP]); // R6

endmodule

// File: rtl/odiv_counter.sv
module odiv_counter
    import odiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_in,
    output logic              phase_hi,
    output logic              pass
);
    logic [CODE_W-1:0] code_act;
    logic [HALF_W-1:0] cnt;
    phase_t            phase;
    div_cfg_t          cfg;
    logic              term;
    logic              reload;

    always_comb begin
        cfg    = decode_code(code_act);
        term   = (cnt == cfg.half - HALF_W'(1));
        reload = cfg.pass || (phase == PH_HIGH && term);
    end

    always_ff @(posedge clk) begin
        if (rst || reload) begin
            code_act <= code_in;
            cnt      <= '0;
            phase    <= PH_LOW;
        end else if (term) begin
            cnt      <= '0;
            phase    <= PH_HIGH;
        end else begin
            cnt      <= cnt + HALF_W'(1);
        end
    end

    assign phase_hi = (phase == PH_HIGH);
    assign pass     = cfg.pass;

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt < cfg.half); // R4

    AST_CODE_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && code_act != $past(code_act))
        |-> ($past(phase == PH_HIGH) || $past(code_act) == CODE_PASS)); // R9

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cnt == '0 && phase == PH_LOW)); // R7

    AST_PASS_PHASE_LOW: assert property (@(posedge clk) disable iff (rst)
        (code_act == CODE_PASS) |-> phase == PH_LOW); // R3

endmodule

// File: rtl/odiv_out_gate.sv
module odiv_out_gate #(
    parameter int NUM_PAIRS = 6
) (
    input  logic                 clk,
    input  logic                 en,
    input  logic                 pass,
    input  logic                 phase_hi,
    output logic [NUM_PAIRS-1:0] fout,
    output logic [NUM_PAIRS-1:0] fout_n
);
    logic src;

    always_comb src = en & (pass ? clk : phase_hi);

    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
        assign fout[i]   = src;
        assign fout_n[i] = ~src;
    end

endmodule

// File: rtl/odiv_top.sv
module odiv_top
    import odiv_pkg::*;
#(
    parameter int NUM_PAIRS   = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk_vco,
    input  logic                 rst,
    input  logic                 oe_async,
    input  logic [CODE_W-1:0]    div_code,
    output logic [NUM_PAIRS-1:0] fout,
    output logic [NUM_PAIRS-1:0] fout_n
);
    logic en_ret;
    logic phase_hi;
    logic pass;

    odiv_oe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk_vco),
        .rst      (rst),
        .oe_async (oe_async),
        .en_ret   (en_ret)
    );

    odiv_counter u_cnt (
        .clk      (clk_vco),
        .rst      (rst),
        .code_in  (div_code),
        .phase_hi (phase_hi),
        .pass     (pass)
    );

    odiv_out_gate #(.NUM_PAIRS(NUM_PAIRS)) u_gate (
        .clk      (clk_vco),
        .en       (en_ret),
        .pass     (pass),
        .phase_hi (phase_hi),
        .fout     (fout),
        .fout_n   (fout_n)
    );

endmodule

// File: tb/odiv_top_tb.sv
`timescale 1ns/100ps
module odiv_top_tb;
    logic       clk_vco = 1'b0;
    logic       rst = 1'b1;
    logic       oe_async = 1'b0;
    logic [2:0] div_code = 3'b000;
    logic [5:0] fout, fout_n;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string cur_tag = "R7";

    int s1_m = 0, s2_m = 0, en_m = 0, n_m = 2, p_m = 0;

    always #2 clk_vco = ~clk_vco;

    odiv_top u_dut (
        .clk_vco  (clk_vco),
        .rst      (rst),
        .oe_async (oe_async),
        .div_code (div_code),
        .fout     (fout),
        .fout_n   (fout_n)
    );

    // Ratio per code as given in R1, R2, R3.
    function automatic int ratio(input logic [2:0] c);
        case (c)
            3'b000: return 2;
            3'b001: return 4;
            3'b010: return 8;
            3'b011: return 16;
            3'b100: return 1;
            3'b101: return 2;
            3'b110: return 4;
            default: return 8;
        endcase
    endfunction

    task automatic compare(input bit exp_bit, input string where);
        n_checks++;
        if (fout[0] !== exp_bit) begin
            n_errors++;
            $display("FAIL %s (%s) t=%0t fout[0] actual %b expected %b",
                     cur_tag, where, $time, fout[0], exp_bit);
        end
        n_checks++; // R8: identical pairs, exact complements
        if (fout !== {6{fout[0]}} || fout_n !== ~fout) begin
            n_errors++;
            $display("FAIL R8 (%s) t=%0t fout %b fout_n %b expected all equal and inverted",
                     where, $time, fout, fout_n);
        end
    endtask

    // Reference model: a period phase counter plus the enable pipeline.
    always @(posedge clk_vco) begin
        bit e;
        if (rst) begin
            s1_m = 0; s2_m = 0; n_m = ratio(div_code); p_m = 0;
        end else begin
            s2_m = s1_m;
            s1_m = oe_async;
            if (n_m == 1 || p_m == n_m - 1) begin
                n_m = ratio(div_code);
                p_m = 0;
            end else begin
                p_m++;
            end
        end
        #1;
        e = (en_m != 0) && (n_m == 1 || p_m >= n_m / 2);
        if (chk_on && !done) compare(e, "high phase");
        #2;
        en_m = rst ? 0 : s2_m;
        e = (en_m != 0) && (n_m > 1 && p_m >= n_m / 2);
        if (chk_on && !done) compare(e, "low phase");
    end

    task automatic go(input int n);
        repeat (n) @(posedge clk_vco);
        #1.5;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R7: reset state
        cur_tag = "R7";
        oe_async = 1'b1;
        go(3);
        chk_on = 1'b1;
        go(4);
        rst = 1'b0;
        // R1: low-bank codes
        cur_tag = "R1";
        div_code = 3'b000; go(12);
        div_code = 3'b001; go(20);
        div_code = 3'b010; go(30);
        div_code = 3'b011; go(50);
        // R4: 50% duty across several full periods
        cur_tag = "R4"; go(64);
        // R2: high-bank codes
        cur_tag = "R2";
        div_code = 3'b101; go(12);
        div_code = 3'b110; go(20);
        div_code = 3'b111; go(30);
        // R3: pass-through
        cur_tag = "R3";
        div_code = 3'b100; go(20);
        // R6: single-cycle enable pulses in pass-through
        cur_tag = "R6";
        oe_async = 1'b0; go(1);
        oe_async = 1'b1; go(6);
        oe_async = 1'b0; go(6);
        oe_async = 1'b1; go(1);
        oe_async = 1'b0; go(6);
        oe_async = 1'b1; go(8);
        // R5: disabled state under a divided code
        cur_tag = "R5";
        div_code = 3'b010; oe_async = 1'b0; go(40);
        div_code = 3'b100; go(10);
        // R6: enable pulses in divide-by-4
        cur_tag = "R6";
        div_code = 3'b001; oe_async = 1'b1; go(9);
        oe_async = 1'b0; go(1);
        oe_async = 1'b1; go(3);
        oe_async = 1'b0; go(2);
        oe_async = 1'b1; go(12);
        // R9: code changes landing at several offsets within a period
        cur_tag = "R9";
        div_code = 3'b011; go(21);
        div_code = 3'b000; go(3);
        div_code = 3'b011; go(5);
        div_code = 3'b111; go(11);
        div_code = 3'b100; go(3);
        div_code = 3'b011; go(7);
        div_code = 3'b100; go(17);
        div_code = 3'b110; go(2);
        div_code = 3'b101; go(1);
        div_code = 3'b010; go(20);
        // R7: reset in the middle of a period
        cur_tag = "R7";
        div_code = 3'b011; go(13);
        rst = 1'b1; go(5);
        rst = 1'b0; cur_tag = "R1"; go(40);
        cur_tag = "R7";
        div_code = 3'b100; go(5);
        rst = 1'b1; go(4);
        rst = 1'b0; cur_tag = "R3"; go(10);
        finish_run();
    end

endmodule